// File: doc/BRIEF.md
# Timeout-Promoted Priority Arbiter

This block shares one memory port among four requesters: a display DMA channel, a signal processor, a local bus, and a general DMA channel. A requester asks for the port by holding its request line high. It keeps the port until it pulses the common transfer-done input. Every requester has its own programmable wait limit.

A waiting request begins in a low-priority pool. Requests in that pool are served in rotating (round-robin) order. Once a request has waited past its limit, it is promoted into a high-priority set. That set is always served first, in a fixed order.

Setting every limit to zero promotes each request one cycle after it appears. The block then acts as a plain fixed-priority arbiter. Large limits make it behave like a fair rotating arbiter. Mixed limits give each requester a latency bound of its own.

Top module: `prio_timeout_arb`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `grant` is 0 and `busy` is 0. Reset clears every wait limit to 0.
- R2: `grant` has at most one bit set. `busy` is 1 exactly when a grant bit is set. Bit 0 is the display DMA channel, bit 1 the signal processor, bit 2 the local bus and bit 3 the general DMA channel.
- R3: A grant does not change until `xfer_done` is sampled high while `busy` is 1.
- R4: `grant` returns to 0 on the clock edge that samples `xfer_done` high. At least one cycle with no grant follows before the next grant.
- R5: A grant goes only to a requester that was asserting its request in the cycle before the grant appears. That request must not already have been granted.
- R6: Promoted requests are served in fixed order: bit 0 first, then bit 1, then bit 2, then bit 3.
- R7: With wait limit L, a request first sampled at edge E counts as promoted from edge E+L+1 onward. With L = 0, a request is promoted from the edge after it is first sampled.
- R8: A promoted request always wins over a request that has not been promoted, whatever the round-robin position.
- R9: When no promoted request is eligible, the eligible request nearest at or after a rotating pointer wins. After any grant to requester i, the pointer moves to i+1 modulo 4, and the pointer resets to 0. Under continuous requests with large limits, grants cycle 0,1,2,3.
- R10: Dropping a request for one cycle, or being granted, restarts that requester's wait count from zero.
- R11: A write with `cfg_we` high stores `cfg_data` into the wait limit chosen by `cfg_idx`. No other limit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Request lines, one per requester |
| xfer_done | input | 1 | Pulse ending the current transfer |
| cfg_we | input | 1 | Wait-limit write enable |
| cfg_idx | input | 2 | Requester whose wait limit is written |
| cfg_data | input | 8 | Wait-limit value |
| grant | output | 4 | One-hot grant |
| busy | output | 1 | Port is owned by a requester |

## Verification
The hardest case to reach is promotion landing on exactly the idle cycle in which the next winner is chosen. A one-cycle shift decides whether the round-robin choice or the promoted requester gets the port. To reach it, the stimulus first parks the port on the general DMA channel, which resets the pointer to 0. It then raises the display and processor requests together, with the processor on a limit of 3. Finally it releases the port either one edge before or exactly on the promotion edge. A wait that was cleared by dropping a request is probed the same way. Full starvation sweeps with continuous requests check the rotation.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NREQ = 4;
    localparam int TW   = 8;
    localparam int IW   = $clog2(NREQ);

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_BUSY = 1'b1
    } port_state_e;

    typedef struct packed {
        logic          valid;
        logic          promoted;
        logic [IW-1:0] idx;
    } pick_t;

    function automatic logic [NREQ-1:0] to_onehot(input logic [IW-1:0] i);
        return NREQ'(1) << i;
    endfunction

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] i);
        return (int'(i) + 1 == NREQ) ? '0 : i + 1'b1;
    endfunction

endpackage

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
    parameter int W = arb_pkg::TW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         granted,
    input  logic [W-1:0] limit,
    output logic         pend,
    output logic         promo
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req || granted) begin
            cnt   <= '0;
            pend  <= 1'b0;
            promo <= 1'b0;
        end else begin
            pend <= 1'b1;
            if (cnt >= limit) begin
                promo <= 1'b1;
            end else if (!promo && cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_select.sv
module arb_select
    import arb_pkg::*;
#(
    parameter int N = arb_pkg::NREQ
) (
    input  logic [N-1:0]  elig,
    input  logic [N-1:0]  promo,
    input  logic [IW-1:0] ptr,
    output pick_t         pick
);
    logic [N-1:0] hi_set;

    always_comb begin
        hi_set = elig & promo;
        pick   = '0;
        // fixed order: lowest index wins, so scan downward
        for (int k = N - 1; k >= 0; k--) begin
            if (hi_set[k]) begin
                pick.valid    = 1'b1;
                pick.promoted = 1'b1;
                pick.idx      = IW'(k);
            end
        end
        if (!pick.valid) begin
            for (int k = N - 1; k >= 0; k--) begin
                if (elig[(int'(ptr) + k) % N]) begin
                    pick.valid = 1'b1;
                    pick.idx   = IW'((int'(ptr) + k) % N);
                end
            end
        end
    end
endmodule

// File: rtl/prio_timeout_arb.sv
module prio_timeout_arb
    import arb_pkg::*;
#(
    parameter int NR = arb_pkg::NREQ,
    parameter int LW = arb_pkg::TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NR-1:0] req,
    input  logic          xfer_done,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [LW-1:0] cfg_data,
    output logic [NR-1:0] grant,
    output logic          busy
);
    logic [LW-1:0] limit_q [NR];
    logic [NR-1:0] pend, promo, grant_q;
    logic [IW-1:0] rr_ptr;
    port_state_e   state;
    pick_t         pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) limit_q[i] <= '0;
        end else if (cfg_we) begin
            limit_q[cfg_idx] <= cfg_data;
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_wait
        arb_wait_ctr #(.W(LW)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .req     (req[g]),
            .granted (grant_q[g]),
            .limit   (limit_q[g]),
            .pend    (pend[g]),
            .promo   (promo[g])
        );
    end

    arb_select #(.N(NR)) u_sel (
        .elig  (pend & req),
        .promo (promo),
        .ptr   (rr_ptr),
        .pick  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PORT_IDLE;
            grant_q <= '0;
            rr_ptr  <= '0;
        end else begin
            unique case (state)
                PORT_IDLE: if (pick.valid) begin
                    state   <= PORT_BUSY;
                    grant_q <= to_onehot(pick.idx);
                    rr_ptr  <= wrap_inc(pick.idx);
                end
                PORT_BUSY: if (xfer_done) begin
                    state   <= PORT_IDLE;
                    grant_q <= '0;
                end
                default: state <= PORT_IDLE;
            endcase
        end
    end

    assign grant = grant_q;
    assign busy  = (state == PORT_BUSY);
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NR = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NR-1:0] req,
    input logic          xfer_done,
    input logic [NR-1:0] grant,
    input logic          busy
);
    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_busy_matches_r2: assert property (@(posedge clk) disable iff (rst)
        busy == (grant != '0));

    p_grant_held_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !xfer_done) |=> $stable(grant));

    p_release_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && xfer_done) |=> (grant == '0));

    p_grant_to_requester_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((grant & $past(req)) != '0));

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (grant == '0 && !busy));
endmodule

bind prio_timeout_arb arb_checker #(.NR(NR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .xfer_done (xfer_done),
    .grant     (grant),
    .busy      (busy)
);

// File: tb/test_prio_timeout_arb.sv
module test_prio_timeout_arb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic       xfer_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [7:0] cfg_data = '0;
    logic [3:0] grant;
    logic       busy;
    int         vectors = 0;
    int         miscompares = 0;
    int         cycles = 0;

    prio_timeout_arb i_prio_timeout_arb (
        .clk(clk), .rst(rst), .req(req), .xfer_done(xfer_done),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .grant(grant), .busy(busy)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic set_limit(input int idx, input int val);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_data = 8'(val);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = '0; xfer_done = 1'b0;
        tick(3);
        chk("R1 grant in reset", grant, 4'b0000);
        chk("R1 busy in reset", {3'b0, busy}, 4'b0000);
        rst = 1'b0;
        tick(1);
        chk("R1 grant after reset", grant, 4'b0000);
    endtask

    task automatic wait_grant(input logic [3:0] exp, input string rq);
        for (int t = 0; t < 300 && grant == '0; t++) tick(1);
        chk(rq, grant, exp);
        chk("R2 busy with grant", {3'b0, busy}, 4'b0001);
    endtask

    task automatic finish_xfer(input int idx, input bit drop);
        xfer_done = 1'b1;
        if (drop) req[idx] = 1'b0;
        tick(1);
        xfer_done = 1'b0;
        chk("R4 idle gap after done", grant, 4'b0000);
    endtask

    // R7 boundary: port released one edge before or on the promotion edge
    task automatic promo_run(input int gap, input logic [3:0] first, input logic [3:0] second);
        req = 4'b1000;
        wait_grant(4'b1000, "R9 lone requester");
        tick(2);
        chk("R3 grant held", grant, 4'b1000);
        req[0] = 1'b1; req[1] = 1'b1;
        tick(gap);
        finish_xfer(3, 1'b1);
        wait_grant(first, "R7 R8 promotion boundary");
        finish_xfer(first == 4'b0001 ? 0 : 1, 1'b1);
        wait_grant(second, "R9 remaining requester");
        finish_xfer(second == 4'b0001 ? 0 : 1, 1'b1);
    endtask

    initial begin
        do_reset();

        // R6: all limits zero -> plain fixed order
        req = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            wait_grant(4'(1 << k), "R6 fixed order");
            finish_xfer(k, 1'b1);
        end
        // R6: pointer would favour 3, fixed order must pick 0
        req = 4'b0010;
        wait_grant(4'b0010, "R5 single request");
        req[0] = 1'b1; req[3] = 1'b1;
        tick(3);
        finish_xfer(1, 1'b1);
        wait_grant(4'b0001, "R6 fixed beats pointer");
        finish_xfer(0, 1'b1);
        wait_grant(4'b1000, "R6 last");
        finish_xfer(3, 1'b1);

        // R11 + R7 + R8: mixed limits
        set_limit(0, 50); set_limit(1, 3); set_limit(2, 50); set_limit(3, 50);
        promo_run(2, 4'b0001, 4'b0010);
        promo_run(3, 4'b0010, 4'b0001);

        // R10: dropped request restarts its wait
        set_limit(2, 3);
        req = 4'b1000;
        wait_grant(4'b1000, "R9 park on 3");
        req[2] = 1'b1;
        tick(8);
        req[2] = 1'b0;
        tick(1);
        req[2] = 1'b1; req[0] = 1'b1;
        finish_xfer(3, 1'b1);
        wait_grant(4'b0001, "R10 wait restarted");
        finish_xfer(0, 1'b1);
        wait_grant(4'b0100, "R10 follower");
        finish_xfer(2, 1'b1);

        // R9: starvation sweep with continuous requests
        do_reset();
        for (int i = 0; i < 4; i++) set_limit(i, 200);
        req = 4'b1111;
        for (int k = 0; k < 16; k++) begin
            wait_grant(4'(1 << (k % 4)), "R9 rotation");
            finish_xfer(k % 4, 1'b0);
        end
        req = '0;
        tick(3);
        chk("R2 idle at end", grant, 4'b0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule